// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block assembles one outgoing Ethernet frame from a chain of descriptor segments and, when asked to, computes a 16-bit ones-complement checksum over the tail of the frame. That checksum is then written back into the frame before the frame leaves. Each segment arrives in two parts. First comes a 32-bit status word on the descriptor stream. Then the segment's data bytes follow on the byte stream. The engine places the bytes in a frame buffer of `BUF_BYTES` (default 2048) entries, adds the qualifying bytes to a running sum, and returns every status word with its ownership bit cleared. When a segment marks the end of a packet, the engine folds the sum, complements it and inserts it big-endian at the requested offset. It then streams the finished frame out with its length.

All three data interfaces use valid/ready. The input side accepts a transfer in any cycle where both valid and ready are high. Ready on the descriptor stream is high only while the engine waits for a new segment. Ready on the byte stream is high only while a segment's bytes are still owed. On the output side, a byte that is offered stays offered, with its data, last flag and length unchanged, until the sink raises ready. The engine accepts no new descriptor until the current frame has fully drained. The transmit enable and the writeback pulse are plain signals.

Top module: `txcsum_engine`

## Requirements
- R1: Status word layout: bit 31 ownership, bit 30 start of packet, bit 29 end of packet, bit 28 checksum enable, bits 27:20 insertion (stuff) offset, bits 19:14 sum start offset, bits 12:0 segment byte count; after reset dsc_ready is 1 and din_ready, out_valid and wb_valid are 0.
- R2: A segment with bit 30 set restarts the frame: the write position and running sum return to zero and both offsets are latched from that segment's word; later segments keep them.
- R3: Only the first BUF_BYTES byte positions of a frame are stored. Excess bytes are still accepted on the byte stream and then discarded, and the frame length saturates at BUF_BYTES.
- R4: Bytes of segments whose bit 28 is set are added to the sum only at positions at or after the start offset, even when that offset lies inside a segment. They are paired big-endian by their distance from the start offset: an even distance gives the high half and an odd distance the low half, so a trailing odd byte is padded with zero.
- R5: On an end-of-packet segment with bit 28 set, the sum is folded with end-around carry, complemented, and written as high byte at the stuff offset and low byte at stuff offset + 1. Without bit 28 the frame leaves exactly as received.
- R6: A completed frame is sent only if tx_enable is 1 when its end-of-packet segment finishes; otherwise it is dropped, and its writebacks are still produced.
- R7: One cycle after a segment's last byte is accepted (or one cycle after a zero-length descriptor), wb_valid is high for exactly one cycle with wb_word equal to the status word with bit 31 cleared.
- R8: The output holds out_data, out_last and out_len stable while out_valid is high and out_ready low; out_last marks the final byte; out_len equals the frame length.
- R9: No descriptor is accepted while a frame is draining, and a frame of zero length emits nothing.
- R10: The sum and the write position carry across segment boundaries, so a frame built from several segments equals the same bytes delivered in one segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Frame emission enable, sampled at end of packet |
| dsc_valid | input | 1 | Status word offered |
| dsc_ready | output | 1 | Engine can take a status word |
| dsc_word | input | 32 | Segment status word |
| din_valid | input | 1 | Data byte offered |
| din_ready | output | 1 | Engine can take a data byte |
| din_byte | input | 8 | Segment data byte |
| wb_valid | output | 1 | Writeback strobe, one cycle per segment |
| wb_word | output | 32 | Status word with ownership cleared |
| out_valid | output | 1 | Frame byte offered |
| out_ready | input | 1 | Sink takes the frame byte |
| out_data | output | 8 | Frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_len | output | 12 | Frame length in bytes |

## Verification
A stale write position, or one that was not restarted, shows up right away as a wrong out_len and shifted bytes in the next frame. A wrong start offset, wrong pairing parity or a lost carry shows up only in the two inserted checksum bytes. Those bytes are compared against an independently folded sum the moment the frame drains. A state machine that loses its place shows up within a segment: a missing or doubled writeback pulse, a descriptor accepted during drain, or output bytes that change while the sink stalls.

// File: rtl/txcs_pkg.sv
package txcs_pkg;
  localparam int STAT_W   = 32;
  localparam int OWN_BIT  = 31;
  localparam int SOP_BIT  = 30;
  localparam int EOP_BIT  = 29;
  localparam int CKS_BIT  = 28;
  localparam int STF_LSB  = 20;
  localparam int STF_W    = 8;
  localparam int STA_LSB  = 14;
  localparam int STA_W    = 6;
  localparam int SLEN_W   = 13;
  localparam int ACC_W    = 32;

  typedef enum logic [2:0] {
    ST_DESC,
    ST_DATA,
    ST_WB,
    ST_STF_HI,
    ST_STF_LO,
    ST_DRAIN
  } eng_state_t;

  // End-around fold of the accumulator, then ones complement.
  function automatic logic [15:0] fold_cpl(input logic [ACC_W-1:0] a);
    logic [16:0] s1;
    logic [16:0] s2;
    s1 = {1'b0, a[15:0]} + {1'b0, a[31:16]};
    s2 = {1'b0, s1[15:0]} + {16'b0, s1[16]};
    return ~s2[15:0];
  endfunction
endpackage

// File: rtl/txcs_frame_buf.sv
module txcs_frame_buf #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/txcs_sum_acc.sv
module txcs_sum_acc
  import txcs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        add_en,
  input  logic        low_half,
  input  logic [7:0]  add_byte,
  output logic [15:0] cks
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] term;

  always_comb begin
    if (low_half) term = {{(ACC_W-8){1'b0}}, add_byte};
    else          term = {{(ACC_W-16){1'b0}}, add_byte, 8'h00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc_q <= '0;
    else if (add_en)   acc_q <= acc_q + term;
  end

  assign cks = fold_cpl(acc_q);

  // R4: the running sum only grows between restarts
  p_sum_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> acc_q >= $past(acc_q));
endmodule

// File: rtl/txcs_seg_ctrl.sv
module txcs_seg_ctrl
  import txcs_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              dsc_valid,
  output logic              dsc_ready,
  input  logic [STAT_W-1:0] dsc_word,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_byte,
  output logic              wb_valid,
  output logic [STAT_W-1:0] wb_word,
  output logic              buf_we,
  output logic [AW-1:0]     buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic [AW-1:0]     buf_raddr,
  output logic              sum_clr,
  output logic              sum_add,
  output logic              sum_low,
  input  logic [15:0]       cks,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic [LEN_W-1:0]  out_len
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(DEPTH);

  eng_state_t        state_q, state_d;
  logic [STAT_W-1:0] stat_q;
  logic [SLEN_W-1:0] remain_q;
  logic [LEN_W-1:0]  pos_q;
  logic [LEN_W-1:0]  rd_q;
  logic [STA_W-1:0]  start_q;
  logic [STF_W-1:0]  stuff_q;

  logic dsc_fire, din_fire, store, out_fire, send_ok;
  logic [LEN_W-1:0] start_l, rel, stf_hi_a, stf_lo_a;
  logic [SLEN_W-1:0] new_len;

  assign dsc_ready = (state_q == ST_DESC);
  assign din_ready = (state_q == ST_DATA);
  assign dsc_fire  = dsc_valid && dsc_ready;
  assign din_fire  = din_valid && din_ready;
  assign store     = din_fire && (pos_q < DEPTH_L);
  assign new_len   = dsc_word[SLEN_W-1:0];

  assign start_l  = {{(LEN_W-STA_W){1'b0}}, start_q};
  assign rel      = pos_q - start_l;
  assign stf_hi_a = {{(LEN_W-STF_W){1'b0}}, stuff_q};
  assign stf_lo_a = stf_hi_a + LEN_W'(1);

  assign sum_clr = dsc_fire && dsc_word[SOP_BIT];
  assign sum_add = store && stat_q[CKS_BIT] && (pos_q >= start_l);
  assign sum_low = rel[0];

  assign wb_valid = (state_q == ST_WB);
  assign wb_word  = stat_q & ~(STAT_W'(1) << OWN_BIT);

  assign out_valid = (state_q == ST_DRAIN);
  assign out_fire  = out_valid && out_ready;
  assign out_last  = out_valid && (rd_q == pos_q - LEN_W'(1));
  assign out_len   = pos_q;
  assign buf_raddr = rd_q[AW-1:0];

  assign send_ok = tx_enable && (pos_q != '0);

  // Buffer write port: data bytes, then the two checksum bytes.
  always_comb begin
    buf_we    = 1'b0;
    buf_waddr = pos_q[AW-1:0];
    buf_wdata = din_byte;
    if (store) begin
      buf_we = 1'b1;
    end else if (state_q == ST_STF_HI) begin
      buf_we    = (stf_hi_a < DEPTH_L);
      buf_waddr = stf_hi_a[AW-1:0];
      buf_wdata = cks[15:8];
    end else if (state_q == ST_STF_LO) begin
      buf_we    = (stf_lo_a < DEPTH_L);
      buf_waddr = stf_lo_a[AW-1:0];
      buf_wdata = cks[7:0];
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_DESC: if (dsc_fire) state_d = (new_len == '0) ? ST_WB : ST_DATA;
      ST_DATA: if (din_fire && remain_q == SLEN_W'(1)) state_d = ST_WB;
      ST_WB: begin
        if (!stat_q[EOP_BIT])      state_d = ST_DESC;
        else if (stat_q[CKS_BIT])  state_d = ST_STF_HI;
        else                       state_d = send_ok ? ST_DRAIN : ST_DESC;
      end
      ST_STF_HI: state_d = ST_STF_LO;
      ST_STF_LO: state_d = send_ok ? ST_DRAIN : ST_DESC;
      ST_DRAIN:  if (out_fire && out_last) state_d = ST_DESC;
      default:   state_d = ST_DESC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_DESC;
      stat_q   <= '0;
      remain_q <= '0;
      pos_q    <= '0;
      rd_q     <= '0;
      start_q  <= '0;
      stuff_q  <= '0;
    end else begin
      state_q <= state_d;
      if (dsc_fire) begin
        stat_q   <= dsc_word;
        remain_q <= new_len;
        if (dsc_word[SOP_BIT]) begin
          pos_q   <= '0;
          start_q <= dsc_word[STA_LSB +: STA_W];
          stuff_q <= dsc_word[STF_LSB +: STF_W];
        end
      end
      if (din_fire) remain_q <= remain_q - SLEN_W'(1);
      if (store)    pos_q    <= pos_q + LEN_W'(1);
      if (state_q != ST_DRAIN) rd_q <= '0;
      else if (out_fire)       rd_q <= rd_q + LEN_W'(1);
    end
  end

  // R7: the writeback never hands ownership back set
  p_wb_own_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !wb_word[OWN_BIT]);
  // R7: the writeback strobe lasts a single cycle
  p_wb_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
  // R3: the write position never passes the buffer size
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= DEPTH_L);
  // R9: no descriptor is taken while a frame drains
  p_no_desc_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !dsc_ready);
  // R8: a stalled output keeps its last flag and length
  p_hold_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_last) && $stable(out_len));
  // R9: an empty frame is never offered
  p_no_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_len != '0);
endmodule

// File: rtl/txcsum_engine.sv
module txcsum_engine
  import txcs_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  localparam int AW = $clog2(BUF_BYTES),
  localparam int LEN_W = $clog2(BUF_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             dsc_valid,
  output logic             dsc_ready,
  input  logic [31:0]      dsc_word,
  input  logic             din_valid,
  output logic             din_ready,
  input  logic [7:0]       din_byte,
  output logic             wb_valid,
  output logic [31:0]      wb_word,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len
);
  logic          buf_we;
  logic [AW-1:0] buf_waddr, buf_raddr;
  logic [7:0]    buf_wdata;
  logic          sum_clr, sum_add, sum_low;
  logic [15:0]   cks;

  txcs_seg_ctrl #(.DEPTH(BUF_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_word(dsc_word),
    .din_valid(din_valid), .din_ready(din_ready), .din_byte(din_byte),
    .wb_valid(wb_valid), .wb_word(wb_word),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .buf_raddr(buf_raddr),
    .sum_clr(sum_clr), .sum_add(sum_add), .sum_low(sum_low), .cks(cks),
    .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_len(out_len)
  );

  txcs_sum_acc u_sum (
    .clk(clk), .rst_n(rst_n), .clr(sum_clr), .add_en(sum_add),
    .low_half(sum_low), .add_byte(din_byte), .cks(cks)
  );

  txcs_frame_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk(clk), .wr_en(buf_we), .wr_addr(buf_waddr), .wr_data(buf_wdata),
    .rd_addr(buf_raddr), .rd_data(out_data)
  );

  // R8: a stalled output byte does not change
  p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data));
  // R1: byte and descriptor streams are never open together
  p_one_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(dsc_ready && din_ready));
endmodule

// File: tb/txcsum_engine_tb.sv
module txcsum_engine_tb;
  localparam int BUF = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_enable = 1'b1;
  logic        dsc_valid = 1'b0;
  logic [31:0] dsc_word = '0;
  logic        din_valid = 1'b0;
  logic [7:0]  din_byte = '0;
  logic        out_ready = 1'b1;
  logic        dsc_ready, din_ready, wb_valid, out_valid, out_last;
  logic [31:0] wb_word;
  logic [7:0]  out_data;
  logic [11:0] out_len;

  always #2.5 clk = ~clk;

  txcsum_engine #(.BUF_BYTES(BUF)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable),
    .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_word(dsc_word),
    .din_valid(din_valid), .din_ready(din_ready), .din_byte(din_byte),
    .wb_valid(wb_valid), .wb_word(wb_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_len(out_len)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit stall_mode = 1'b0;

  // Capture of outputs
  logic [7:0]  got [BUF];
  int          got_n = 0, got_last = 0, len_bad = 0, hold_bad = 0, drain_bad = 0;
  logic [31:0] wb_log [8];
  int          wb_n = 0;
  logic        pv_valid = 1'b0, pv_ready = 1'b0;
  logic [7:0]  pv_data = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (got_n < BUF) got[got_n] = out_data;
        if (out_len != 12'(exp_len)) len_bad++;
        got_n++;
        if (out_last) got_last++;
      end
      if (out_valid && dsc_ready) drain_bad++;
      if (pv_valid && !pv_ready && (!out_valid || out_data != pv_data)) hold_bad++;
      if (wb_valid) begin
        if (wb_n < 8) wb_log[wb_n] = wb_word;
        wb_n++;
      end
      pv_valid = out_valid; pv_ready = out_ready; pv_data = out_data;
    end
  end

  always @(negedge clk) out_ready <= stall_mode ? (cyc[0] ^ cyc[2]) : 1'b1;

  // Expected-frame model
  logic [7:0] m_buf [BUF];
  int m_pos = 0, m_start = 0, m_stuff = 0, exp_len = 0;
  longint m_sum = 0;
  logic [31:0] seg_w [8];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'((i * 29 + f * 71 + 5) ^ (i >> 3));
  endfunction

  function automatic logic [15:0] ref_cks(input longint s);
    longint t;
    t = s;
    while (t > 64'hFFFF) t = (t & 64'hFFFF) + (t >> 16);
    return ~16'(t);
  endfunction

  function automatic logic [31:0] mkw(input bit sop, input bit eop, input bit ck,
                                      input int stf, input int sta, input int len);
    return {1'b1, sop, eop, ck, 8'(stf), 6'(sta), 1'b0, 13'(len)};
  endfunction

  task automatic push_desc(input logic [31:0] w);
    @(negedge clk);
    dsc_valid = 1'b1; dsc_word = w;
    while (!dsc_ready) @(negedge clk);
    @(posedge clk); #1 dsc_valid = 1'b0;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    din_valid = 1'b1; din_byte = b;
    while (!din_ready) @(negedge clk);
    @(posedge clk); #1 din_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    @(negedge clk);
    while (!dsc_ready && k < 20000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  // Sends nseg segments from seg_w with pattern data, then checks all outputs.
  task automatic run_frame(input int nseg, input int fid, input bit exp_out, input string req);
    int idx;
    got_n = 0; got_last = 0; wb_n = 0; len_bad = 0; hold_bad = 0; drain_bad = 0;
    idx = 0;
    for (int s = 0; s < nseg; s++) begin
      logic [31:0] w;
      w = seg_w[s];
      if (w[30]) begin
        m_pos = 0; m_sum = 0; m_start = int'(w[19:14]); m_stuff = int'(w[27:20]);
      end
      push_desc(w);
      for (int k = 0; k < int'(w[12:0]); k++) begin
        logic [7:0] b;
        b = pat(fid, idx); idx++;
        if (m_pos < BUF) begin
          m_buf[m_pos] = b;
          if (w[28] && m_pos >= m_start)
            m_sum += ((m_pos - m_start) % 2 == 0) ? longint'(b) * 256 : longint'(b);
          m_pos++;
        end
        push_byte(b);
      end
      if (w[29] && w[28]) begin
        logic [15:0] c;
        c = ref_cks(m_sum);
        if (m_stuff < BUF)     m_buf[m_stuff]     = c[15:8];
        if (m_stuff + 1 < BUF) m_buf[m_stuff + 1] = c[7:0];
      end
      if (s == 0) exp_len = m_pos;
      else        exp_len = m_pos;
    end
    wait_idle();
    chk(wb_n == nseg, {req, " R7 writeback count"}, wb_n, nseg);
    for (int s = 0; s < nseg && s < 8; s++)
      chk(wb_log[s] == (seg_w[s] & 32'h7FFF_FFFF), {req, " R7 writeback word"},
          wb_log[s], seg_w[s] & 32'h7FFF_FFFF);
    if (exp_out) begin
      int mism;
      mism = 0;
      chk(got_n == exp_len, {req, " R8 byte count"}, got_n, exp_len);
      chk(got_last == 1 && len_bad == 0, {req, " R8 last/len"}, got_last * 1000 + len_bad, 1000);
      for (int i = 0; i < got_n && i < BUF; i++)
        if (got[i] !== m_buf[i]) mism++;
      chk(mism == 0, {req, " frame bytes"}, mism, 0);
      if (m_stuff + 1 < exp_len && seg_w[nseg-1][28])
        chk({got[m_stuff], got[m_stuff+1]} == {m_buf[m_stuff], m_buf[m_stuff+1]},
            {req, " R5 checksum"}, {got[m_stuff], got[m_stuff+1]},
            {m_buf[m_stuff], m_buf[m_stuff+1]});
    end else begin
      chk(got_n == 0, {req, " no output"}, got_n, 0);
    end
    chk(drain_bad == 0 && hold_bad == 0, {req, " R8 R9 drain rules"},
        drain_bad * 1000 + hold_bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(dsc_ready && !din_ready && !out_valid && !wb_valid, "R1 reset state",
        {dsc_ready, din_ready, out_valid, wb_valid}, 4'b1000);
  endtask

  task automatic t_single();
    seg_w[0] = mkw(1, 1, 1, 10, 4, 20);
    run_frame(1, 1, 1, "R4 R5 single segment");
  endtask

  task automatic t_multi();
    seg_w[0] = mkw(1, 0, 1, 2, 9, 7);
    seg_w[1] = mkw(0, 0, 1, 0, 0, 5);
    seg_w[2] = mkw(0, 1, 1, 0, 0, 9);
    run_frame(3, 2, 1, "R10 R4 R2 multi segment odd");
  endtask

  task automatic t_nocks();
    seg_w[0] = mkw(1, 1, 0, 3, 0, 16);
    run_frame(1, 3, 1, "R5 no checksum");
  endtask

  task automatic t_disabled();
    tx_enable = 1'b0;
    seg_w[0] = mkw(1, 0, 1, 4, 0, 6);
    seg_w[1] = mkw(0, 1, 1, 0, 0, 6);
    run_frame(2, 4, 0, "R6 transmit disabled");
    tx_enable = 1'b1;
    seg_w[0] = mkw(1, 1, 1, 6, 2, 12);
    run_frame(1, 5, 1, "R6 R2 after drop");
  endtask

  task automatic t_overflow();
    seg_w[0] = mkw(1, 0, 1, 100, 0, 2000);
    seg_w[1] = mkw(0, 1, 1, 0, 0, 100);
    run_frame(2, 6, 1, "R3 overflow");
    chk(exp_len == BUF, "R3 model length", exp_len, BUF);
  endtask

  task automatic t_stall();
    stall_mode = 1'b1;
    seg_w[0] = mkw(1, 1, 1, 0, 2, 33);
    run_frame(1, 7, 1, "R8 backpressure");
    stall_mode = 1'b0;
  endtask

  task automatic t_zero();
    seg_w[0] = mkw(1, 1, 1, 0, 0, 0);
    run_frame(1, 8, 0, "R9 zero frame");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_multi();
    t_nocks();
    t_disabled();
    t_overflow();
    t_stall();
    t_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule